// File: doc/BRIEF.md
# Guarded Watchdog Timer

The block is an 8-bit watchdog. A free-running prescaler divides the system clock by 8192, and each prescaler tick advances an up-counter. If software does not reload the counter in time, it wraps from 0xFF to 0x00. On that wrap the block drives a one-cycle internal reset pulse and latches a reset-cause flag, so that software can tell after restart that the watchdog caused the reset. The CPU can read and write the counter at any time through a small register port. Reloading the counter with a low value is the normal way to service the watchdog.

The control/status register guards its two stored bits. Each stored bit has a companion inhibit bit, and software updates a stored bit only by writing 0 to its inhibit bit in the same write. The inhibit bits are not stored and always read back as 1. The stored enable bit gates clearing of the reset-cause flag. Software can never set the flag. The watchdog's own reset clears the counter and prescaler but leaves the flag and the enable bit intact. Only the external reset pin returns them to 0.

The pulse is produced by a two-state sequencer. In state `ST_COUNT` the output is low. The transition `COUNT->FIRE` is taken on the edge where the counter wraps. In state `ST_FIRE` the output is high, and the transition `FIRE->COUNT` is always taken on the next edge. A second wrap cannot occur that soon, because one increment needs at least two clocks and a wrap needs 256 increments.

Top module: `wdt_guarded`

## Requirements
- R1: While `rst_pin_ni` is low (asynchronous, active low), the counter, prescaler, flag and enable bit are all 0 and `wdt_rst_o` is low. After release, a read of address 0 returns 0x82 and a read of address 1 returns 0x00.
- R2: The counter (read at address 1) advances by exactly one on every 2^PRE_W-th clock. The default PRE_W is 13, giving 8192 clocks per step. The prescaler runs freely and is not restarted by counter writes.
- R3: On the edge where the counter wraps from 0xFF to 0x00, the flag (address 0, bit 0) is set to 1. `wdt_rst_o` is high for exactly the one following cycle.
- R4: A write with `addr_i`=1 loads `wdata_i` into the counter on that edge. If the write coincides with a prescaler tick, the written value is kept, no increment occurs and no overflow is produced.
- R5: Bit 7 and bit 1 of address 0 always read as 1, whatever was last written to them.
- R6: The enable bit (address 0, bit 6) takes `wdata_i[6]` only on a write to address 0 with `wdata_i[7]`=0. A write with `wdata_i[7]`=1 leaves it unchanged.
- R7: The flag is cleared only by a write to address 0 with `wdata_i[1]`=0 and `wdata_i[0]`=0, and only while the enable bit is 1. The enable value used is the one held before that write. A write with `wdata_i[1]`=1, or one made while the enable bit is 0, leaves the flag unchanged.
- R8: No write ever sets the flag. Writing `wdata_i[0]`=1 with `wdata_i[1]`=0 leaves a cleared flag at 0.
- R9: The watchdog's own reset clears the counter and the prescaler but keeps the flag and the enable bit. When an overflow and an unlocked clearing write fall on the same edge, the flag ends at 1.
- R10: Bits 5 to 2 of address 0 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_pin_ni | input | 1 | External reset pin, active low, asynchronous |
| addr_i | input | 1 | Register select: 0 control/status, 1 counter |
| wr_i | input | 1 | Write strobe, one write per cycle it is high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register, combinational |
| wdt_rst_o | output | 1 | Internal reset request, one-cycle pulse on overflow |

## Verification
The bench builds the block with PRE_W=3, so the counter steps every 8 clocks and a full wrap from a loaded 0xFF or 0xFE takes only a few ticks. This makes overflow, the single-cycle pulse and the preservation of flag and enable across the internal reset reachable many times within the run. The short period also lets the bench place a CPU write on the exact tick edge: one such write loads 0xFF and one overwrites a pending wrap. It also lets the bench make an overflow coincide with an unlocked clearing write. At the default PRE_W, a single wrap would need about two million clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 8;

    // control/status bit positions (read layout is decoded by software)
    localparam int CSR_EN_WI   = 7;
    localparam int CSR_EN      = 6;
    localparam int CSR_FLAG_WI = 1;
    localparam int CSR_FLAG    = 0;

    localparam logic ADDR_CSR = 1'b0;
    localparam logic ADDR_CNT = 1'b1;

    typedef enum logic {
        ST_COUNT = 1'b0,
        ST_FIRE  = 1'b1
    } wdt_state_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W = 13
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_q <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick_o = &pre_q;

    // R2: a tick is followed by a restart of the division period
    p_tick_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (pre_q == '0));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // CPU load has priority over the tick
    assign ovf_o = tick_i && !load_i && (&cnt_q);

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (ovf_o) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

    p_load_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (cnt_q == $past(load_val_i)));

    p_hold_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !tick_i) |=> $stable(cnt_q));

    p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
    import wdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              wr_en_wi_i,
    input  logic              wr_en_i,
    input  logic              wr_flag_wi_i,
    input  logic              wr_flag_i,
    input  logic              ovf_i,
    output logic              flag_o,
    output logic [DATA_W-1:0] csr_o
);

    logic en_q;
    logic flag_q;
    logic en_d;
    logic flag_d;
    logic clr_req;

    // unlocked clear uses the enable held before this write
    assign clr_req = wr_i && en_q && !wr_flag_wi_i && !wr_flag_i;

    always_comb begin
        flag_d = flag_q;
        if (ovf_i) begin
            flag_d = 1'b1;
        end else if (clr_req) begin
            flag_d = 1'b0;
        end
    end

    always_comb begin
        en_d = en_q;
        if (wr_i && !wr_en_wi_i) begin
            en_d = wr_en_i;
        end
    end

    // only the pin reset reaches these bits
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q   <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            en_q   <= en_d;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        csr_o              = '0;
        csr_o[CSR_EN_WI]   = 1'b1;
        csr_o[CSR_EN]      = en_q;
        csr_o[CSR_FLAG_WI] = 1'b1;
        csr_o[CSR_FLAG]    = flag_q;
    end

    assign flag_o = flag_q;

    p_no_sw_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag_q && !ovf_i) |=> !flag_q);

    p_locked_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_q && !ovf_i) |=> $stable(flag_q));

    p_ovf_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i |=> flag_q);

    p_en_guarded_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && !wr_en_wi_i) |=> $stable(en_q));

endmodule

// File: rtl/wdt_guarded.sv
module wdt_guarded
    import wdt_pkg::*;
#(
    parameter int PRE_W = 13,
    parameter int CNT_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_pin_ni,
    input  logic              addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              wdt_rst_o
);

    wdt_state_e        state_q;
    wdt_state_e        state_d;
    logic              tick;
    logic              ovf;
    logic              cnt_load;
    logic              csr_wr;
    logic              flag;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] csr_rd;

    assign cnt_load = wr_i && (addr_i == ADDR_CNT);
    assign csr_wr   = wr_i && (addr_i == ADDR_CSR);

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_pin_ni),
        .clr_i  (ovf),
        .tick_o (tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_pin_ni),
        .tick_i     (tick),
        .load_i     (cnt_load),
        .load_val_i (wdata_i[CNT_W-1:0]),
        .cnt_o      (cnt),
        .ovf_o      (ovf)
    );

    wdt_csr u_csr (
        .clk_i        (clk_i),
        .rst_ni       (rst_pin_ni),
        .wr_i         (csr_wr),
        .wr_en_wi_i   (wdata_i[CSR_EN_WI]),
        .wr_en_i      (wdata_i[CSR_EN]),
        .wr_flag_wi_i (wdata_i[CSR_FLAG_WI]),
        .wr_flag_i    (wdata_i[CSR_FLAG]),
        .ovf_i        (ovf),
        .flag_o       (flag),
        .csr_o        (csr_rd)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_pin_ni) begin
        if (!rst_pin_ni) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        wdt_rst_o = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                if (ovf) begin
                    state_d = ST_FIRE;
                end
            end
            ST_FIRE: begin
                wdt_rst_o = 1'b1;
                state_d   = ST_COUNT;
            end
            default: state_d = ST_COUNT;
        endcase
    end

    assign rdata_o = (addr_i == ADDR_CNT) ? DATA_W'(cnt) : csr_rd;

    p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (!rst_pin_ni)
        wdt_rst_o |=> !wdt_rst_o);

    p_pulse_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_pin_ni)
        wdt_rst_o |-> flag);

    p_pulse_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_pin_ni)
        (wdt_rst_o && !$past(cnt_load)) |-> (cnt == '0));

endmodule

// File: tb/wdt_guarded_tb_top.sv
module wdt_guarded_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 3;
    localparam int PRE_MAX    = (1 << PRE_W) - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wrst;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pre, m_cnt;
    bit m_flag, m_en, m_pulse, t_tick, t_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guarded #(.PRE_W(PRE_W), .CNT_W(8)) dut_i (
        .clk_i      (clk),
        .rst_pin_ni (rst_n),
        .addr_i     (addr),
        .wr_i       (wr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .wdt_rst_o  (wrst)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_flag = 0; m_en = 0; m_pulse = 0;
        end else begin
            t_tick = (m_pre == PRE_MAX);
            m_pre  = (m_pre + 1) % (PRE_MAX + 1);
            t_ovf  = 0;
            if (wr && addr) m_cnt = int'(wdata);
            else if (t_tick) begin
                if (m_cnt == 255) begin m_cnt = 0; t_ovf = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_pulse = t_ovf;
            if (t_ovf) m_flag = 1;
            else if (wr && !addr && m_en && wdata[1:0] == 2'b00) m_flag = 0;
            if (wr && !addr && !wdata[7]) m_en = wdata[6];
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every falling edge; inputs move 1 time unit later
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        exp_rd = addr ? 8'(m_cnt) : {1'b1, m_en, 4'b0000, 1'b1, m_flag};
        check({cur_req, " rdata"}, rdata, exp_rd);
        check({cur_req, " R3 pulse"}, {7'd0, wrst}, {7'd0, m_pulse});
    end

    task automatic step();
        @(negedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            wr = 1'b0; addr = ~addr;
        end
    endtask

    task automatic wr_now(logic a, logic [7:0] d);
        addr = a; wr = 1'b1; wdata = d;
        step();
    endtask

    task automatic wr_reg(logic a, logic [7:0] d);
        @(negedge clk); #1;
        wr_now(a, d);
    endtask

    task automatic rd(logic a, logic [7:0] exp, string tag);
        @(negedge clk); #1;
        wr = 1'b0; addr = a;
        @(negedge clk);
        check(tag, rdata, exp);
    endtask

    task automatic wait_tick_slot();
        while (m_pre != PRE_MAX) begin
            @(negedge clk); #1;
            wr = 1'b0;
        end
    endtask

    task automatic pin_reset();
        @(negedge clk); #1;
        rst_n = 1'b0; wr = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        rd(0, 8'h82, "R1 csr after reset");
        rd(1, 8'h00, "R1 counter after reset");

        cur_req = "R2";
        idle(60);
        cur_req = "R10";
        rd(0, 8'h82, "R10 reserved bits zero");

        cur_req = "R4";
        wr_reg(1, 8'h37);
        idle(20);

        cur_req = "R3";
        wr_reg(1, 8'hFE);
        idle(24);
        rd(0, 8'h83, "R3 flag set by overflow");

        cur_req = "R6";
        wr_reg(0, 8'hC0);
        rd(0, 8'h83, "R6 enable kept when bit7 written 1");

        cur_req = "R7";
        wr_reg(0, 8'h00);
        rd(0, 8'h83, "R7 locked clear ignored");
        wr_reg(0, 8'h40);
        rd(0, 8'hC3, "R7 clear uses old enable");
        wr_reg(0, 8'h42);
        rd(0, 8'hC3, "R7 inhibit bit protects flag");
        wr_reg(0, 8'h40);
        rd(0, 8'hC2, "R7 unlocked clear");

        cur_req = "R8";
        wr_reg(0, 8'h41);
        rd(0, 8'hC2, "R8 software cannot set flag");
        cur_req = "R5";
        wr_reg(0, 8'hC3);
        rd(0, 8'hC2, "R5 inhibit bits read one");

        cur_req = "R4";
        wait_tick_slot();
        wr_now(1, 8'hFF);
        wait_tick_slot();
        wr_now(1, 8'h10);
        rd(1, 8'h10, "R4 write wins over tick");
        rd(0, 8'hC2, "R4 no overflow on collision");

        cur_req = "R9";
        wait_tick_slot();
        wr_now(1, 8'hFF);
        wait_tick_slot();
        wr_now(0, 8'h40);
        rd(0, 8'hC3, "R9 overflow beats clear, enable kept");
        rd(1, 8'h00, "R9 counter cleared by internal reset");

        cur_req = "R2";
        idle(300);

        cur_req = "R1";
        pin_reset();
        rd(0, 8'h82, "R1 pin reset clears flag and enable");
        idle(10);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule